// File: doc/BRIEF.md
# Adaptive Clock Calibration Controller

This block closes a frequency-tuning loop around a timing-critical datapath, such as a long carry chain. It owns an up/down frequency code that steers an external clock generator: a larger code means a faster clock. A timing checker outside the block watches the slowest output of the datapath. For each check it reports one of three outcomes. Either the result came too late, or it settled early enough to leave the required safety margin, or it fell in between. The margin itself is built into the checker's delayed sample.

Operands reach the datapath through this block. After reset, the controller shuts the operand stream and feeds the datapath the pattern that ripples a carry through every bit. It then moves the code one step at a time until the checker reports the in-between outcome, and then it opens the stream. From then on, whenever that same pattern arrives in live traffic, the controller takes one more check and makes at most one step. Each code change is followed by a hold window of programmable length. During that window no operand reaches the datapath, so nothing evaluates while the clock is moving.

Input stream rules: `in_ready` is high only in normal operation. An operand pair transfers on a cycle with both `in_valid` and `in_ready` high. Outside normal operation the block applies back-pressure by holding `in_ready` low, and the source must keep its data. The output stream has no ready, because the datapath accepts a pair on every cycle that `out_valid` is high.

Top module: `clk_cal_ctrl`

## Requirements
- R1: While reset is held, `freq_code` is 0x80, and `hold_eval`, `in_ready` and `out_valid` are all 0.
- R2: On the first cycle after reset, the block drives the worst-case pair out_a=0xFFFF, out_b=0x0001 with `out_valid` high. `in_ready` stays low for the whole startup calibration.
- R3: `chk_valid` is only acted on while the block waits for a check result. In that state, `chk_late`=1 lowers the code, `chk_late`=0 with `chk_early`=1 raises it, and both 0 means stop: the code is kept and the block returns to normal operation. Late wins when both flags are 1.
- R4: A decision moves `freq_code` by exactly one step, and no check produces more than one step.
- R5: The code saturates. A raise at 0xFF leaves 0xFF and a lower at 0x00 leaves 0x00. The hold window still occurs in both cases.
- R6: After a raise or lower decision, `hold_eval` is high for exactly `settle_cycles`+1 consecutive cycles, using the value of `settle_cycles` at the start of the window. While it is high, `in_ready` and `out_valid` are 0.
- R7: Startup calibration repeats the sequence of forced vector, check, step and hold until a stop decision. Then `in_ready` rises with the code unchanged.
- R8: In normal operation, `out_a`/`out_b` equal `in_a`/`in_b` in the same cycle, `out_valid` equals `in_valid`, and `in_ready` is 1.
- R9: In normal operation, an accepted pair that exactly equals A=0xFFFF, B=0x0001 starts one in-situ check. `in_ready` drops on the next cycle and returns after the decision is handled, with at most one code step. Any other pair starts nothing.
- R10: `freq_code` changes only as the result of a check decision. A `chk_valid` pulse during normal operation has no effect on the code or the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Live operand pair valid |
| in_ready | output | 1 | Block accepts live operands |
| in_a | input | 16 | Live operand A |
| in_b | input | 16 | Live operand B |
| out_valid | output | 1 | Operand pair to datapath valid |
| out_a | output | 16 | Operand A to datapath |
| out_b | output | 16 | Operand B to datapath |
| chk_valid | input | 1 | Timing check result valid |
| chk_late | input | 1 | Output was not complete at the sampling edge |
| chk_early | input | 1 | Output was complete even at the margin-delayed sample |
| settle_cycles | input | 4 | Extra hold cycles after each code change |
| freq_code | output | 8 | Frequency control code to the clock generator |
| hold_eval | output | 1 | Datapath evaluation blocked during a code change |

## Verification
The bench sweeps every value of `settle_cycles` and measures each hold window against it. A timer that is off by one would give windows one cycle too short or too long, and would let operands slip through while the clock is moving. It drives the code into both rails during startup. A wrapping counter would jump from 0xFF to 0x00 instead of staying put. It tries near-miss operand pairs, sends checker pulses during normal operation, and sets both flags at once. A loose comparator, a stray decision path or the wrong priority would each show up as a code step or a dropped `in_ready` where none is expected. It also checks that a single in-situ occurrence yields at most one step, which catches a design that stays in the startup loop.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_FORCE  = 3'd1,
    S_WAIT   = 3'd2,
    S_ADJUST = 3'd3,
    S_SETTLE = 3'd4,
    S_RUN    = 3'd5
  } cal_state_e;

endpackage

// File: rtl/cal_vec_detect.sv
module cal_vec_detect #(
  parameter int OPND_W = 16
) (
  input  logic [OPND_W-1:0] a,
  input  logic [OPND_W-1:0] b,
  output logic [OPND_W-1:0] vec_a,
  output logic [OPND_W-1:0] vec_b,
  output logic              hit
);

  logic [OPND_W-1:0] bit_match;

  assign vec_a = {OPND_W{1'b1}};
  assign vec_b = OPND_W'(1);

  // per-bit match: A all ones, B one only in bit 0
  for (genvar i = 0; i < OPND_W; i++) begin : g_match
    if (i == 0) begin : g_lsb
      assign bit_match[i] = a[i] & b[i];
    end else begin : g_upper
      assign bit_match[i] = a[i] & ~b[i];
    end
  end

  assign hit = &bit_match;

endmodule

// File: rtl/cal_code_ctr.sv
module cal_code_ctr #(
  parameter int              CODE_W    = 8,
  parameter logic [CODE_W-1:0] CODE_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_up,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= CODE_INIT;
    end else if (step_en) begin
      if (step_up && code != CODE_MAX) begin
        code <= code + CODE_W'(1);
      end else if (!step_up && code != CODE_MIN) begin
        code <= code - CODE_W'(1);
      end
    end
  end

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code != $past(code)) |->
      ((code == $past(code) + CODE_W'(1)) || (code == $past(code) - CODE_W'(1))));

  p_no_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_MAX && step_en && step_up) |=> (code == CODE_MAX));

  p_no_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_MIN && step_en && !step_up) |=> (code == CODE_MIN));

endmodule

// File: rtl/cal_settle_tmr.sv
module cal_settle_tmr #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] load_val,
  output logic                last
);

  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - SETTLE_W'(1);
    end
  end

  assign last = (cnt == SETTLE_W'(1));

  p_settle_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - SETTLE_W'(1)));

endmodule

// File: rtl/clk_cal_ctrl.sv
module clk_cal_ctrl
  import clk_cal_pkg::*;
#(
  parameter int                OPND_W    = 16,
  parameter int                CODE_W    = 8,
  parameter logic [CODE_W-1:0] CODE_INIT = 8'h80,
  parameter int                SETTLE_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OPND_W-1:0]   in_a,
  input  logic [OPND_W-1:0]   in_b,
  output logic                out_valid,
  output logic [OPND_W-1:0]   out_a,
  output logic [OPND_W-1:0]   out_b,
  input  logic                chk_valid,
  input  logic                chk_late,
  input  logic                chk_early,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [CODE_W-1:0]   freq_code,
  output logic                hold_eval
);

  cal_state_e        state, state_nx;
  logic              startup_q;
  logic              dec_up_q;
  logic              vec_hit;
  logic              settle_last;
  logic [OPND_W-1:0] vec_a, vec_b;
  logic              accept;
  cal_state_e        exit_st;

  cal_vec_detect #(.OPND_W(OPND_W)) u_detect (
    .a     (in_a),
    .b     (in_b),
    .vec_a (vec_a),
    .vec_b (vec_b),
    .hit   (vec_hit)
  );

  cal_code_ctr #(.CODE_W(CODE_W), .CODE_INIT(CODE_INIT)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (state == S_ADJUST),
    .step_up (dec_up_q),
    .code    (freq_code)
  );

  cal_settle_tmr #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == S_ADJUST),
    .load_val (settle_cycles),
    .last     (settle_last)
  );

  assign accept  = in_valid && in_ready;
  assign exit_st = startup_q ? S_FORCE : S_RUN;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:   state_nx = S_FORCE;
      S_FORCE:  state_nx = S_WAIT;
      S_WAIT:   if (chk_valid) state_nx = (chk_late || chk_early) ? S_ADJUST : S_RUN;
      S_ADJUST: state_nx = (settle_cycles == '0) ? exit_st : S_SETTLE;
      S_SETTLE: if (settle_last) state_nx = exit_st;
      S_RUN:    if (accept && vec_hit) state_nx = S_WAIT;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      startup_q <= 1'b1;
      dec_up_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state_nx == S_RUN) startup_q <= 1'b0;
      if (state == S_WAIT && chk_valid) dec_up_q <= !chk_late;
    end
  end

  assign hold_eval = (state == S_ADJUST) || (state == S_SETTLE);
  assign in_ready  = (state == S_RUN);
  assign out_valid = (state == S_FORCE) || (state == S_RUN && in_valid);
  assign out_a     = (state == S_FORCE) ? vec_a : in_a;
  assign out_b     = (state == S_FORCE) ? vec_b : in_b;

  p_hold_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_eval |-> (!in_ready && !out_valid));

  p_stop_to_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && chk_valid && !chk_late && !chk_early) |=>
      (state == S_RUN && freq_code == $past(freq_code)));

  p_code_moves_on_decision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_code != $past(freq_code)) |-> ($past(state) == S_ADJUST));

  p_insitu_trigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && in_valid && vec_hit) |=> !in_ready);

endmodule

// File: tb/test_clk_cal_ctrl.sv
module test_clk_cal_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_a, in_b;
  logic        out_valid;
  logic [15:0] out_a, out_b;
  logic        chk_valid, chk_late, chk_early;
  logic [3:0]  settle_cycles;
  logic [7:0]  freq_code;
  logic        hold_eval;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  // monitor state
  logic [7:0] prev_code;
  bit  prev_hold;
  int  len, exp_len, exp_dir, pulses;
  int  startup_viol, hold_viol;
  bit  startup_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_cal_ctrl i_clk_cal_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
    .chk_valid(chk_valid), .chk_late(chk_late), .chk_early(chk_early),
    .settle_cycles(settle_cycles), .freq_code(freq_code), .hold_eval(hold_eval)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // hold window length, step size/direction, blocking during hold
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_code = 8'h80;
      prev_hold = 1'b0;
    end else begin
      if (hold_eval && !prev_hold) begin
        exp_len = int'(settle_cycles) + 1;
        len     = 1;
        exp_dir = chk_late ? -1 : (chk_early ? 1 : 0);
      end else if (hold_eval) begin
        len++;
      end
      if (!hold_eval && prev_hold) begin
        pulses++;
        check(len == exp_len, "R6 hold length", len, exp_len);
      end
      if (freq_code != prev_code)
        check(freq_code == 8'(int'(prev_code) + exp_dir), "R4 single step",
              freq_code, 8'(int'(prev_code) + exp_dir));
      if (hold_eval && (in_ready || out_valid)) hold_viol++;
      if (startup_phase && in_ready) startup_viol++;
      prev_hold = hold_eval;
      prev_code = freq_code;
    end
  end

  task automatic wait_hold_low();
    @(negedge clk);
    while (hold_eval) @(negedge clk);
  endtask

  task automatic wait_ready(input int max, input string req);
    int n = 0;
    while (!in_ready && n < max) begin
      @(negedge clk);
      n++;
    end
    check(in_ready == 1'b1, req, in_ready, 1);
  endtask

  task automatic wait_code(input logic [7:0] target, input int max, input string req);
    int n = 0;
    while (freq_code != target && n < max) begin
      @(negedge clk);
      n++;
    end
    check(freq_code == target, req, freq_code, target);
  endtask

  task automatic insitu(input bit late, input bit early, input logic [7:0] exp_code,
                        input int exp_pulses, input string req);
    int p0;
    @(negedge clk);
    chk_valid = 1'b1; chk_late = late; chk_early = early;
    in_a = 16'hFFFF; in_b = 16'h0001; in_valid = 1'b1;
    p0 = pulses;
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R9 in-situ trigger drops ready", in_ready, 0);
    wait_ready(80, "R9 returns to normal operation");
    @(negedge clk);
    check(freq_code == exp_code, req, freq_code, exp_code);
    check(pulses - p0 == exp_pulses, "R9 hold windows per occurrence", pulses - p0, exp_pulses);
  endtask

  initial begin
    logic [7:0] code_snap;
    int p_snap;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    chk_valid = 1'b1; chk_late = 1'b0; chk_early = 1'b1;
    settle_cycles = 4'd0;
    pulses = 0; startup_viol = 0; hold_viol = 0; startup_phase = 1'b1;
    repeat (3) @(negedge clk);
    check(freq_code == 8'h80, "R1 reset code", freq_code, 8'h80);
    check(hold_eval == 1'b0, "R1 reset hold", hold_eval, 0);
    check(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R2 forced vector valid", out_valid, 1);
    check(out_a == 16'hFFFF, "R2 forced A", out_a, 16'hFFFF);
    check(out_b == 16'h0001, "R2 forced B", out_b, 16'h0001);

    // sweep every settle length during startup raising
    for (int s = 0; s < 16; s++) begin
      int p0;
      wait_hold_low();
      settle_cycles = 4'(s);
      p0 = pulses;
      while (pulses < p0 + 2) @(negedge clk);
    end

    // R5 upper rail
    wait_hold_low();
    settle_cycles = 4'd0;
    wait_code(8'hFF, 2000, "R5 reaches upper rail");
    p_snap = pulses;
    repeat (40) @(negedge clk);
    check(freq_code == 8'hFF, "R5 saturates at 0xFF", freq_code, 8'hFF);
    check(pulses > p_snap, "R5 hold still occurs at rail", pulses, p_snap + 1);

    // lower: late and early both set, late wins (R3)
    wait_hold_low();
    chk_late = 1'b1; chk_early = 1'b1;
    wait_code(8'hFE, 40, "R3 late wins over early");
    wait_hold_low();
    chk_early = 1'b0; settle_cycles = 4'd1;
    wait_code(8'h00, 3000, "R5 reaches lower rail");
    repeat (40) @(negedge clk);
    check(freq_code == 8'h00, "R5 saturates at 0x00", freq_code, 8'h00);

    // stop decision ends startup (R7)
    wait_hold_low();
    chk_late = 1'b0; chk_early = 1'b0;
    wait_ready(80, "R7 stop opens the stream");
    startup_phase = 1'b0;
    @(negedge clk);
    check(freq_code == 8'h00, "R7 code kept on stop", freq_code, 8'h00);
    check(startup_viol == 0, "R2 ready low during startup", startup_viol, 0);

    // pass-through with checker pulses present (R8, R9 near misses, R10)
    chk_valid = 1'b1; chk_early = 1'b1;
    code_snap = freq_code;
    p_snap = pulses;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] ta, tb;
      unique case (i)
        0: begin ta = 16'hFFFF; tb = 16'h0000; end
        1: begin ta = 16'hFFFE; tb = 16'h0001; end
        2: begin ta = 16'hFFFF; tb = 16'h0003; end
        3: begin ta = 16'h7FFF; tb = 16'h0001; end
        4: begin ta = 16'hFFFF; tb = 16'h8001; end
        5: begin ta = 16'h0001; tb = 16'hFFFF; end
        default: begin ta = 16'(i * 16'h1111); tb = 16'(i * 3 + 2); end
      endcase
      @(negedge clk);
      in_a = ta; in_b = tb; in_valid = i[0] | (i < 6);
      #1;
      check(in_ready == 1'b1, "R8 ready in normal operation", in_ready, 1);
      check(out_valid == in_valid, "R8 valid follows", out_valid, in_valid);
      check(out_a == ta && out_b == tb, "R8 operands pass through", {out_a, out_b}, {ta, tb});
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(freq_code == code_snap, "R10 checker pulses ignored in normal operation", freq_code, code_snap);
    check(pulses == p_snap, "R9 near misses start nothing", pulses, p_snap);
    check(in_ready == 1'b1, "R9 near misses keep ready", in_ready, 1);

    // in-situ calibration
    settle_cycles = 4'd3;
    insitu(1'b0, 1'b1, 8'h01, 1, "R9 in-situ raise one step");
    insitu(1'b0, 1'b1, 8'h02, 1, "R4 one step per occurrence");
    insitu(1'b1, 1'b1, 8'h01, 1, "R3 in-situ late wins");
    settle_cycles = 4'd2;
    insitu(1'b1, 1'b0, 8'h00, 1, "R9 in-situ lower");
    insitu(1'b1, 1'b0, 8'h00, 1, "R5 in-situ lower at rail");
    insitu(1'b0, 1'b0, 8'h00, 0, "R3 in-situ stop keeps code");

    check(hold_viol == 0, "R6 stream blocked during hold", hold_viol, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule